// File: doc/BRIEF.md
# Line-Sync Aligned Pixel Counter

This block keeps the horizontal pixel position for an image-sensor timing engine. It runs on the incoming pixel clock and watches two active-low sync inputs: a line sync and a frame sync. Every falling edge of the line sync is taken in on a rising clock edge and then registered a second time at the internal sampling point. A fixed-length delay pipeline follows, and at its end the pixel counter is cleared to zero. A one-cycle strobe marks the clear. Between clears the counter advances once per clock and stops at its largest value.

The clear arrives after one of two fixed latencies, chosen by a one-bit select input. The select stands in for the choice between the two possible sampling-edge locations. The block also polices the ordering of the two syncs. A line-sync fall may happen in the same cycle as a frame-sync fall, or in any later cycle. A line-sync fall that comes exactly one cycle before a frame-sync fall is illegal. It sets a sticky error flag, which stays set until a clear input is pulsed.

Top module: `hsync_pixel_counter`

## Requirements
- R1: `hd_in` and `vd_in` are sampled on rising edges of `clk`. A falling edge is two consecutive samples, 1 and then 0. Edge 1 is the first rising edge that samples the line sync low.
- R2: With `lat_sel` = 0, the cycle that follows rising edge 13 (counted from edge 1) shows `pix_cnt` = 0 and `cnt_clr_pulse` = 1. The cycle that follows edge 12 shows `cnt_clr_pulse` = 0.
- R3: With `lat_sel` = 1, the clear and the strobe appear after edge 14 instead. `lat_sel` must be held from the line-sync fall until the clear.
- R4: In every cycle without a clear, `pix_cnt` rises by exactly 1. After clear edge L plus m further edges it reads m.
- R5: `pix_cnt` saturates at 2^CNT_W-1 (4095 by default) and holds that value until the next clear. A clear taken while saturated still gives 0.
- R6: A frame-sync fall in the same cycle as a line-sync fall does not set `order_err`. Neither does a frame-sync fall two or more cycles after it, nor one before it.
- R7: A line-sync fall sampled at edge k followed by a frame-sync fall sampled at edge k+1 sets `order_err`. The flag becomes visible after edge k+2 and stays set without further stimulus.
- R8: `err_clr` = 1 at a rising edge clears `order_err`. If a set condition falls on the same edge, the set wins and the flag stays 1.
- R9: A synchronous active-high `rst` forces `pix_cnt` = 0, `cnt_clr_pulse` = 0 and `order_err` = 0. It also empties the sync and delay pipeline, so a line-sync fall that is in flight before the reset never produces a strobe.
- R10: `cnt_clr_pulse` is high for exactly one cycle per line-sync fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising-edge active |
| rst | input | 1 | Synchronous reset, active high |
| hd_in | input | 1 | External line sync, active low |
| vd_in | input | 1 | External frame sync, active low |
| lat_sel | input | 1 | Reset latency choice: 0 = 13 edges, 1 = 14 edges |
| err_clr | input | 1 | Synchronous clear of the ordering error flag |
| pix_cnt | output | CNT_W | Horizontal pixel count |
| cnt_clr_pulse | output | 1 | One-cycle strobe marking the counter clear |
| order_err | output | 1 | Sticky sync-ordering violation flag |

## Verification
Two events can land on the same edge: the ordering flag being set by an illegal sync pair, and its clear request. The bench first leaves the flag set from one violation. It then repeats an illegal pair and raises `err_clr` on exactly the edge where the new violation registers. The flag must read 1 afterwards, and a lone clear pulse must bring it back to 0. A second collision is a clear taken while the counter sits at saturation. It is provoked by a very long line, and the bench expects zero on the clear edge.

// File: rtl/pxc_pkg.sv
package pxc_pkg;

    // Number of capture registers between the pin and the internal sampling point
    localparam int unsigned SYNC_DEPTH = 2;
    // Shorter of the two clear latencies, counted in rising edges from edge 1
    localparam int unsigned BASE_LAT   = 13;

    typedef enum logic {
        LAT_SHORT = 1'b0,
        LAT_LONG  = 1'b1
    } lat_sel_e;

    // Edge events produced by one synchronizer
    typedef struct packed {
        logic fall_early;   // fall seen at the first capture register
        logic fall_int;     // fall seen at the internal sampling point
    } edge_ev_t;

    // Delay taps needed so that both latency choices are available
    function automatic int unsigned delay_len(input int unsigned lat, input int unsigned depth);
        return lat - depth;
    endfunction

endpackage

// File: rtl/pxc_sync_edge.sv
module pxc_sync_edge
    import pxc_pkg::*;
#(
    parameter int unsigned DEPTH = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     din,
    output edge_ev_t ev
);

    // sh[0] is the pin capture, sh[DEPTH-1] the internal sample, sh[DEPTH] its history
    logic [DEPTH:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '1;
        end else begin
            sh <= {sh[DEPTH-1:0], din};
        end
    end

    always_comb begin
        ev.fall_early = sh[1] & ~sh[0];
        ev.fall_int   = sh[DEPTH] & ~sh[DEPTH-1];
    end

    // R1: a fall taken at the pin reaches the internal sampling point DEPTH-1 edges later
    p_capture_chain_r1: assert property (@(posedge clk) disable iff (rst)
        ev.fall_early |-> ##(DEPTH-1) ev.fall_int);

endmodule

// File: rtl/pxc_delay_line.sv
module pxc_delay_line #(
    parameter int unsigned LEN = 11
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           din,
    output logic [LEN-1:0] taps
);

    always_ff @(posedge clk) begin
        if (rst) begin
            taps <= '0;
        end else begin
            taps <= {taps[LEN-2:0], din};
        end
    end

    // R2: every event advances one tap per edge without loss
    genvar gi;
    generate
        for (gi = 0; gi < LEN - 1; gi++) begin : g_chk
            p_tap_advance_r2: assert property (@(posedge clk) disable iff (rst)
                taps[gi] |=> taps[gi+1]);
        end
    endgenerate

endmodule

// File: rtl/pxc_pix_counter.sv
module pxc_pix_counter #(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt,
    output logic             strobe
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            strobe <= 1'b0;
        end else begin
            strobe <= clr;
            if (clr) begin
                cnt <= '0;
            end else if (cnt != CNT_MAX) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R4: steady increment between clears
    p_step_r4: assert property (@(posedge clk) disable iff (rst)
        (!clr && cnt != CNT_MAX) |=> cnt == $past(cnt) + 1'b1);
    // R5: saturation holds
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        (!clr && cnt == CNT_MAX) |=> cnt == CNT_MAX);
    // R2: strobe always coincides with a zero count
    p_strobe_zero_r2: assert property (@(posedge clk) disable iff (rst)
        strobe |-> cnt == '0);

endmodule

// File: rtl/pxc_order_check.sv
module pxc_order_check (
    input  logic clk,
    input  logic rst,
    input  logic hd_fall,
    input  logic vd_fall,
    input  logic err_clr,
    output logic err
);

    logic hd_fall_d;
    logic violation;

    assign violation = hd_fall_d & vd_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            hd_fall_d <= 1'b0;
            err       <= 1'b0;
        end else begin
            hd_fall_d <= hd_fall;
            if (violation) begin
                err <= 1'b1;
            end else if (err_clr) begin
                err <= 1'b0;
            end
        end
    end

    // R7: the flag is sticky while no clear is requested
    p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (err && !err_clr) |=> err);
    // R8: a set always wins over a clear
    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
        violation |=> err);
    // R6: same-cycle falls never count as a violation
    p_same_cycle_ok_r6: assert property (@(posedge clk) disable iff (rst)
        (!err && !hd_fall_d && !err_clr) |=> !err);

endmodule

// File: rtl/hsync_pixel_counter.sv
module hsync_pixel_counter
    import pxc_pkg::*;
#(
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hd_in,
    input  logic             vd_in,
    input  logic             lat_sel,
    input  logic             err_clr,
    output logic [CNT_W-1:0] pix_cnt,
    output logic             cnt_clr_pulse,
    output logic             order_err
);

    localparam int unsigned DLY_LEN = delay_len(BASE_LAT, SYNC_DEPTH);

    edge_ev_t               hd_ev;
    edge_ev_t               vd_ev;
    logic [DLY_LEN-1:0]     taps;
    logic                   clr_now;
    lat_sel_e               lat_mode;

    pxc_sync_edge #(.DEPTH(SYNC_DEPTH)) u_hd_sync (
        .clk (clk),
        .rst (rst),
        .din (hd_in),
        .ev  (hd_ev)
    );

    pxc_sync_edge #(.DEPTH(SYNC_DEPTH)) u_vd_sync (
        .clk (clk),
        .rst (rst),
        .din (vd_in),
        .ev  (vd_ev)
    );

    pxc_delay_line #(.LEN(DLY_LEN)) u_delay (
        .clk  (clk),
        .rst  (rst),
        .din  (hd_ev.fall_int),
        .taps (taps)
    );

    assign lat_mode = lat_sel_e'(lat_sel);

    always_comb begin
        case (lat_mode)
            LAT_LONG: clr_now = taps[DLY_LEN-1];
            default:  clr_now = taps[DLY_LEN-2];
        endcase
    end

    pxc_pix_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .clr    (clr_now),
        .cnt    (pix_cnt),
        .strobe (cnt_clr_pulse)
    );

    pxc_order_check u_order (
        .clk     (clk),
        .rst     (rst),
        .hd_fall (hd_ev.fall_early),
        .vd_fall (vd_ev.fall_early),
        .err_clr (err_clr),
        .err     (order_err)
    );

    // R10: a single fall never yields back-to-back strobes
    p_single_strobe_r10: assert property (@(posedge clk) disable iff (rst)
        cnt_clr_pulse |=> !cnt_clr_pulse);

endmodule

// File: tb/hsync_pixel_counter_tb.sv
module hsync_pixel_counter_tb;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 12;
    localparam int CMAX       = (1 << CNT_W) - 1;
    localparam int LAT0       = 13;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             hd_in = 1'b1;
    logic             vd_in = 1'b1;
    logic             lat_sel = 1'b0;
    logic             err_clr = 1'b0;
    logic [CNT_W-1:0] pix_cnt;
    logic             cnt_clr_pulse;
    logic             order_err;

    int checks   = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hsync_pixel_counter #(.CNT_W(CNT_W)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .hd_in         (hd_in),
        .vd_in         (vd_in),
        .lat_sel       (lat_sel),
        .err_clr       (err_clr),
        .pix_cnt       (pix_cnt),
        .cnt_clr_pulse (cnt_clr_pulse),
        .order_err     (order_err)
    );

    function automatic int exp_count(input int m);
        return (m > CMAX) ? CMAX : m;
    endfunction

    function automatic int exp_latency(input logic sel);
        return sel ? LAT0 + 1 : LAT0;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // One line: HD falls before edge 1, stays low low_len edges, line lasts lat+extra edges
    task automatic run_line(input logic sel, input int low_len, input int extra, input bit dense);
        int lat;
        lat = exp_latency(sel);
        lat_sel = sel;
        hd_in = 1'b0;
        for (int i = 1; i <= lat + extra; i++) begin
            step();
            if (i == low_len) hd_in = 1'b1;
            if (i == lat - 1)
                check(cnt_clr_pulse == 1'b0, sel ? "R3" : "R2", cnt_clr_pulse, 0);
            if (i == lat) begin
                check(cnt_clr_pulse == 1'b1, sel ? "R3" : "R2", cnt_clr_pulse, 1);
                check(pix_cnt == 0, sel ? "R3" : "R2", pix_cnt, 0);
            end
            if (i > lat && (dense || i == lat + extra || i == lat + 1)) begin
                check(pix_cnt == exp_count(i - lat), (i - lat > CMAX) ? "R5" : "R4",
                      pix_cnt, exp_count(i - lat));
                check(cnt_clr_pulse == 1'b0, "R10", cnt_clr_pulse, 0);
            end
        end
        hd_in = 1'b1;
    endtask

    task automatic pulse_clear();
        err_clr = 1'b1;
        step();
        err_clr = 1'b0;
    endtask

    // hd_at / vd_at: loop index at which each sync falls
    task automatic order_case(input int hd_at, input int vd_at, input bit expect_err,
                              input bit collide, input string req);
        for (int j = 0; j < 8; j++) begin
            if (j == hd_at) hd_in = 1'b0;
            if (j == vd_at) vd_in = 1'b0;
            err_clr = (collide && j == hd_at + 2) ? 1'b1 : 1'b0;
            step();
        end
        err_clr = 1'b0;
        check(order_err == expect_err, req, order_err, expect_err);
        hd_in = 1'b1;
        vd_in = 1'b1;
        for (int j = 0; j < 20; j++) step();
        check(order_err == expect_err, expect_err ? "R7" : req, order_err, expect_err);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        @(negedge clk);
        step();
        step();
        // R9: reset state
        check(pix_cnt == 0, "R9", pix_cnt, 0);
        check(cnt_clr_pulse == 1'b0, "R9", cnt_clr_pulse, 0);
        check(order_err == 1'b0, "R9", order_err, 0);
        rst = 1'b0;
        step();
        step();

        // Directed latency checks, R1 R2 R3 R4 R10
        run_line(1'b0, 1, 20, 1'b1);
        run_line(1'b1, 3, 20, 1'b1);
        run_line(1'b0, 12, 5, 1'b1);
        run_line(1'b1, 14, 5, 1'b1);

        // R5: long line to saturation, then a clear from saturation
        run_line(1'b0, 2, CMAX + 10, 1'b0);
        check(pix_cnt == CMAX, "R5", pix_cnt, CMAX);
        run_line(1'b1, 2, 3, 1'b1);

        // Ordering checks R6 R7 R8
        order_case(0, 0, 1'b0, 1'b0, "R6");
        order_case(0, 2, 1'b0, 1'b0, "R6");
        order_case(1, 0, 1'b0, 1'b0, "R6");
        order_case(3, 0, 1'b0, 1'b0, "R6");
        order_case(0, 1, 1'b1, 1'b0, "R7");
        // flag still set; repeat a violation with clear on the same edge
        order_case(0, 1, 1'b1, 1'b1, "R8");
        pulse_clear();
        check(order_err == 1'b0, "R8", order_err, 0);
        for (int j = 0; j < 5; j++) step();
        check(order_err == 1'b0, "R8", order_err, 0);

        // Random lines
        for (int n = 0; n < 40; n++) begin
            logic s;
            int lo;
            int ex;
            s  = logic'($urandom_range(0, 1));
            lo = $urandom_range(1, 16);
            ex = $urandom_range(2, 40);
            run_line(s, lo, ex, 1'b1);
        end

        // R9: reset while a fall is in flight, with the flag set beforehand
        order_case(0, 1, 1'b1, 1'b0, "R7");
        hd_in = 1'b0;
        for (int j = 0; j < 5; j++) step();
        hd_in = 1'b1;
        rst = 1'b1;
        step();
        step();
        check(pix_cnt == 0, "R9", pix_cnt, 0);
        check(order_err == 1'b0, "R9", order_err, 0);
        rst = 1'b0;
        begin
            int seen;
            seen = 0;
            for (int j = 0; j < 25; j++) begin
                step();
                if (cnt_clr_pulse) seen++;
            end
            check(seen == 0, "R9", seen, 0);
            check(pix_cnt == 25, "R9", pix_cnt, 25);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule